// File: doc/BRIEF.md
# Multicycle Instruction Sequencing Controller

This block is the control unit of a small 16-bit load/store machine with eight general registers. It steps each instruction through fetch, decode, address evaluation, operand fetch, execution and result write. In every cycle it drives the datapath: the load enables for the instruction register, program counter, memory address and data registers, register file and condition codes. It also drives the one-hot selector that picks the single source allowed onto the shared bus, plus the multiplexer selects, the ALU operation and the memory strobes.

The datapath feeds back the top seven instruction-register bits and the three condition flags. Memory is one word-addressed port that is reached only through the address and data registers. It acknowledges each access with a ready input after any number of cycles. Phases an instruction does not need are skipped. The two indirect forms make two trips through the single port: one for the pointer and one for the data.

States: BOOT, FETCH_ADDR, FETCH_READ, FETCH_IR, DECODE, ALU_WB, LEA_WB, EA_PC, EA_BASE, PTR_READ, PTR_MAR, LOAD_READ, LOAD_WB, STORE_DATA, STORE_WRITE, BRANCH, JUMP, HALT. Transitions:

- BOOT→FETCH_ADDR→FETCH_READ (held until ready)→FETCH_IR→DECODE.
- DECODE dispatches to one of:
  - ALU_WB for the operate group;
  - LEA_WB;
  - EA_PC for LD, ST, LDI and STI;
  - EA_BASE for LDR and STR;
  - JUMP;
  - BRANCH when a branch is taken, or FETCH_ADDR when it is not;
  - HALT for any other opcode.
- EA_PC goes to PTR_READ for the indirect forms. Otherwise EA_PC and EA_BASE go to LOAD_READ for loads or STORE_DATA for stores.
- PTR_READ (held until ready) goes to PTR_MAR, which goes to LOAD_READ or STORE_DATA.
- LOAD_READ (held until ready) goes to LOAD_WB.
- STORE_DATA goes to STORE_WRITE, which is held until ready.
- ALU_WB, LEA_WB, LOAD_WB, STORE_WRITE, BRANCH and JUMP all return to FETCH_ADDR.
- HALT holds until reset.

Top module: `instr_seq_ctrl`

## Requirements

Output vector encodings:
- bus_gate bits: bit0 = PC, bit1 = MDR, bit2 = ALU, bit3 = address adder.
- pc_src: 0 = increment, 1 = address adder, 2 = reset vector.
- addr_off: 0 = zero, 1 = 6-bit field, 2 = 9-bit field.
- alu_op: 0 = add, 1 = and, 2 = not, 3 = pass.

Requirements:
- R1: During reset, and in the first cycle after it, only ld_pc is high, with pc_src=2. This loads the datapath's reset vector (16'h3000), and fetch follows.
- R2: FETCH_ADDR raises ld_mar and ld_pc with bus_gate=0001, mar_src=0 and pc_src=0. FETCH_READ then reads memory. FETCH_IR then raises ld_ir with bus_gate=0010.
- R3: In every memory state, mem_en stays high and the state holds while mem_rdy is low. ld_mdr (with mdr_src=0) is high only in the read cycle where mem_rdy is high.
- R4: DECODE is one cycle with all outputs low. The opcode is ir_hi[6:3]. ADD=0001, AND=0101 and NOT=1001 take one ALU_WB cycle with bus_gate=0100, ld_reg, ld_cc and alu_op 0, 1 or 2 respectively.
- R5: LEA (1110) takes one cycle with bus_gate=1000, addr_base=0, addr_off=2, ld_reg and ld_cc, and no memory access.
- R6: LD (0010) loads MAR from the adder (mar_src=1) with PC base and addr_off=2. LDR (0110) does the same with register base (addr_base=1) and addr_off=1. Both then read memory, then raise ld_reg and ld_cc with bus_gate=0010.
- R7: ST (0011) and STR (0111) load MAR as in R6. Next comes a cycle with bus_gate=0100, alu_op=3, ld_mdr and mdr_src=1. Then mem_en and mem_we stay high until ready, and fetch follows.
- R8: LDI (1010) and STI (1011) first read a pointer at PC plus the 9-bit offset. Then a cycle with bus_gate=0010 and ld_mar (mar_src=0) loads that pointer into MAR. The load or store sequence of R6 or R7 follows.
- R9: BR (0000) is taken when any flag selected by ir_hi[2:0] is set in cc_nzp (bit2=N, bit1=Z, bit0=P). A taken branch takes one cycle with ld_pc, pc_src=1, addr_base=0 and addr_off=2. A branch that is not taken goes from DECODE straight to fetch.
- R10: JMP (1100) takes one cycle with ld_pc, pc_src=1, addr_base=1 and addr_off=0.
- R11: Opcodes 0100, 1000, 1101 and 1111 lead to HALT. There halt is high and every other output is low, whatever mem_rdy does, until reset.
- R12: At most one bus_gate bit is high in any cycle. Every output not named for a state in these requirements is 0 in that state.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_hi | input | 7 | IR bits 15:9: opcode and branch flag mask |
| cc_nzp | input | 3 | Condition flags N, Z, P |
| mem_rdy | input | 1 | Memory access complete |
| ld_ir | output | 1 | Load instruction register |
| ld_pc | output | 1 | Load program counter |
| ld_mar | output | 1 | Load memory address register |
| ld_mdr | output | 1 | Load memory data register |
| ld_reg | output | 1 | Write register file |
| ld_cc | output | 1 | Update condition flags |
| bus_gate | output | 4 | One-hot bus source select |
| pc_src | output | 2 | PC input select |
| mar_src | output | 1 | MAR input: 0 bus, 1 adder |
| mdr_src | output | 1 | MDR input: 0 memory, 1 bus |
| addr_base | output | 1 | Adder base: 0 PC, 1 register |
| addr_off | output | 2 | Adder offset select |
| alu_op | output | 2 | ALU operation |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| halt | output | 1 | Halted on an unsupported opcode |

## Verification

The bench builds the controller with its default field widths: a 4-bit opcode and a 3-bit flag mask. With these widths all sixteen decode lines can be reached. That brings every implemented opcode, and each of the four codes that must halt, into the directed runs. Memory latency is varied from zero to three wait cycles inside fetch, pointer, load and store accesses. This exposes the hold behaviour of each wait state and the ready-qualified data load. Branches are run against matching, non-matching and empty flag masks.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [4:0] {
        S_BOOT, S_F_ADDR, S_F_READ, S_F_IR, S_DEC,
        S_ALU_WB, S_LEA_WB, S_EA_PC, S_EA_BASE,
        S_PTR_RD, S_PTR_MAR, S_LD_RD, S_LD_WB,
        S_ST_DATA, S_ST_WR, S_BRANCH, S_JUMP, S_HALT
    } state_t;

    typedef enum logic [2:0] {G_NONE, G_PC, G_MDR, G_ALU, G_ADR} gate_t;
    typedef enum logic [1:0] {PC_INC = 2'd0, PC_ADR = 2'd1, PC_VEC = 2'd2} pc_src_t;
    typedef enum logic [1:0] {OFF_ZERO = 2'd0, OFF_6 = 2'd1, OFF_9 = 2'd2} off_t;
    typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_AND = 2'd1, ALU_NOT = 2'd2, ALU_PASS = 2'd3} alu_t;

    localparam int OP_BR  = 0;
    localparam int OP_ADD = 1;
    localparam int OP_LD  = 2;
    localparam int OP_ST  = 3;
    localparam int OP_AND = 5;
    localparam int OP_LDR = 6;
    localparam int OP_STR = 7;
    localparam int OP_NOT = 9;
    localparam int OP_LDI = 10;
    localparam int OP_STI = 11;
    localparam int OP_JMP = 12;
    localparam int OP_LEA = 14;

    typedef struct packed {
        logic    ld_ir;
        logic    ld_pc;
        logic    ld_mar;
        logic    ld_mdr;
        logic    ld_reg;
        logic    ld_cc;
        gate_t   gate;
        pc_src_t pc_src;
        logic    mar_adr;
        logic    mdr_bus;
        logic    base_reg;
        off_t    off;
        alu_t    alu;
        logic    mem_en;
        logic    mem_we;
        logic    halt;
    } ctl_t;

endpackage

// File: rtl/seq_opdec.sv
module seq_opdec #(
    parameter int OPC_W = 4,
    localparam int NLINE = 1 << OPC_W
) (
    input  logic [OPC_W-1:0] opc,
    output logic [NLINE-1:0] line
);
    for (genvar i = 0; i < NLINE; i++) begin : g_line
        assign line[i] = (opc == OPC_W'(i));
    end
endmodule

// File: rtl/seq_brcond.sv
module seq_brcond #(
    parameter int CC_W = 3
) (
    input  logic [CC_W-1:0] mask,
    input  logic [CC_W-1:0] flags,
    output logic            taken
);
    assign taken = |(mask & flags);
endmodule

// File: rtl/seq_next.sv
module seq_next
    import seq_pkg::*;
#(
    parameter int OPC_W = 4,
    localparam int NLINE = 1 << OPC_W
) (
    input  state_t           cur,
    input  logic [NLINE-1:0] line,
    input  logic             taken,
    input  logic             mem_rdy,
    output state_t           nxt,
    output alu_t             alu_kind
);
    localparam logic [NLINE-1:0] SUPPORTED = NLINE'(16'h5EEF);

    logic legal, grp_op, grp_pcrel, grp_base, is_load, is_ind;

    always_comb begin
        legal     = |(line & SUPPORTED);
        grp_op    = line[OP_ADD] | line[OP_AND] | line[OP_NOT];
        grp_pcrel = line[OP_LD] | line[OP_ST] | line[OP_LDI] | line[OP_STI];
        grp_base  = line[OP_LDR] | line[OP_STR];
        is_load   = line[OP_LD] | line[OP_LDR] | line[OP_LDI];
        is_ind    = line[OP_LDI] | line[OP_STI];
        if (line[OP_AND])      alu_kind = ALU_AND;
        else if (line[OP_NOT]) alu_kind = ALU_NOT;
        else                   alu_kind = ALU_ADD;
    end

    always_comb begin
        nxt = cur;
        unique case (cur)
            S_BOOT:    nxt = S_F_ADDR;
            S_F_ADDR:  nxt = S_F_READ;
            S_F_READ:  if (mem_rdy) nxt = S_F_IR;
            S_F_IR:    nxt = S_DEC;
            S_DEC: begin
                if (!legal)             nxt = S_HALT;
                else if (grp_op)        nxt = S_ALU_WB;
                else if (line[OP_LEA])  nxt = S_LEA_WB;
                else if (grp_pcrel)     nxt = S_EA_PC;
                else if (grp_base)      nxt = S_EA_BASE;
                else if (line[OP_JMP])  nxt = S_JUMP;
                else                    nxt = taken ? S_BRANCH : S_F_ADDR;
            end
            S_EA_PC:   nxt = is_ind ? S_PTR_RD : (is_load ? S_LD_RD : S_ST_DATA);
            S_EA_BASE: nxt = is_load ? S_LD_RD : S_ST_DATA;
            S_PTR_RD:  if (mem_rdy) nxt = S_PTR_MAR;
            S_PTR_MAR: nxt = is_load ? S_LD_RD : S_ST_DATA;
            S_LD_RD:   if (mem_rdy) nxt = S_LD_WB;
            S_ST_DATA: nxt = S_ST_WR;
            S_ST_WR:   if (mem_rdy) nxt = S_F_ADDR;
            S_ALU_WB, S_LEA_WB, S_LD_WB, S_BRANCH, S_JUMP: nxt = S_F_ADDR;
            S_HALT:    nxt = S_HALT;
            default:   nxt = S_HALT;
        endcase
    end
endmodule

// File: rtl/seq_ctlgen.sv
module seq_ctlgen
    import seq_pkg::*;
(
    input  state_t cur,
    input  alu_t   alu_kind,
    input  logic   mem_rdy,
    output ctl_t   c
);
    always_comb begin
        c = '0;
        unique case (cur)
            S_BOOT: begin
                c.ld_pc  = 1'b1;
                c.pc_src = PC_VEC;
            end
            S_F_ADDR: begin
                c.gate   = G_PC;
                c.ld_mar = 1'b1;
                c.ld_pc  = 1'b1;
                c.pc_src = PC_INC;
            end
            S_F_READ, S_PTR_RD, S_LD_RD: begin
                c.mem_en = 1'b1;
                c.ld_mdr = mem_rdy;
            end
            S_F_IR: begin
                c.gate  = G_MDR;
                c.ld_ir = 1'b1;
            end
            S_DEC: c = '0;
            S_ALU_WB: begin
                c.gate   = G_ALU;
                c.alu    = alu_kind;
                c.ld_reg = 1'b1;
                c.ld_cc  = 1'b1;
            end
            S_LEA_WB: begin
                c.gate   = G_ADR;
                c.off    = OFF_9;
                c.ld_reg = 1'b1;
                c.ld_cc  = 1'b1;
            end
            S_EA_PC: begin
                c.ld_mar  = 1'b1;
                c.mar_adr = 1'b1;
                c.off     = OFF_9;
            end
            S_EA_BASE: begin
                c.ld_mar   = 1'b1;
                c.mar_adr  = 1'b1;
                c.base_reg = 1'b1;
                c.off      = OFF_6;
            end
            S_PTR_MAR: begin
                c.gate   = G_MDR;
                c.ld_mar = 1'b1;
            end
            S_LD_WB: begin
                c.gate   = G_MDR;
                c.ld_reg = 1'b1;
                c.ld_cc  = 1'b1;
            end
            S_ST_DATA: begin
                c.gate    = G_ALU;
                c.alu     = ALU_PASS;
                c.ld_mdr  = 1'b1;
                c.mdr_bus = 1'b1;
            end
            S_ST_WR: begin
                c.mem_en = 1'b1;
                c.mem_we = 1'b1;
            end
            S_BRANCH: begin
                c.ld_pc  = 1'b1;
                c.pc_src = PC_ADR;
                c.off    = OFF_9;
            end
            S_JUMP: begin
                c.ld_pc    = 1'b1;
                c.pc_src   = PC_ADR;
                c.base_reg = 1'b1;
                c.off      = OFF_ZERO;
            end
            S_HALT: c.halt = 1'b1;
            default: c = '0;
        endcase
    end
endmodule

// File: rtl/instr_seq_ctrl.sv
module instr_seq_ctrl
    import seq_pkg::*;
#(
    parameter int OPC_W = 4,
    parameter int CC_W  = 3,
    localparam int NLINE  = 1 << OPC_W,
    localparam int HI_W   = OPC_W + CC_W,
    localparam int GATE_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HI_W-1:0]   ir_hi,
    input  logic [CC_W-1:0]   cc_nzp,
    input  logic              mem_rdy,
    output logic              ld_ir,
    output logic              ld_pc,
    output logic              ld_mar,
    output logic              ld_mdr,
    output logic              ld_reg,
    output logic              ld_cc,
    output logic [GATE_N-1:0] bus_gate,
    output logic [1:0]        pc_src,
    output logic              mar_src,
    output logic              mdr_src,
    output logic              addr_base,
    output logic [1:0]        addr_off,
    output logic [1:0]        alu_op,
    output logic              mem_en,
    output logic              mem_we,
    output logic              halt
);
    state_t           st_q, st_d;
    logic [NLINE-1:0] line;
    logic             taken;
    alu_t             alu_kind;
    ctl_t             ctl;

    seq_opdec #(.OPC_W(OPC_W)) u_dec (
        .opc  (ir_hi[HI_W-1 -: OPC_W]),
        .line (line)
    );

    seq_brcond #(.CC_W(CC_W)) u_br (
        .mask  (ir_hi[CC_W-1:0]),
        .flags (cc_nzp),
        .taken (taken)
    );

    seq_next #(.OPC_W(OPC_W)) u_next (
        .cur      (st_q),
        .line     (line),
        .taken    (taken),
        .mem_rdy  (mem_rdy),
        .nxt      (st_d),
        .alu_kind (alu_kind)
    );

    seq_ctlgen u_ctl (
        .cur      (st_q),
        .alu_kind (alu_kind),
        .mem_rdy  (mem_rdy),
        .c        (ctl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_BOOT;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < GATE_N; g++) begin : g_gate
        assign bus_gate[g] = (ctl.gate == gate_t'(3'(g + 1)));
    end

    assign ld_ir     = ctl.ld_ir;
    assign ld_pc     = ctl.ld_pc;
    assign ld_mar    = ctl.ld_mar;
    assign ld_mdr    = ctl.ld_mdr;
    assign ld_reg    = ctl.ld_reg;
    assign ld_cc     = ctl.ld_cc;
    assign pc_src    = ctl.pc_src;
    assign mar_src   = ctl.mar_adr;
    assign mdr_src   = ctl.mdr_bus;
    assign addr_base = ctl.base_reg;
    assign addr_off  = ctl.off;
    assign alu_op    = ctl.alu;
    assign mem_en    = ctl.mem_en;
    assign mem_we    = ctl.mem_we;
    assign halt      = ctl.halt;
endmodule

// File: rtl/instr_seq_ctrl_chk.sv
module instr_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_rdy,
    input logic       mem_en,
    input logic       mem_we,
    input logic       ld_ir,
    input logic       ld_mdr,
    input logic       ld_mar,
    input logic       halt,
    input logic [3:0] bus_gate
);
    // R12
    bus_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_gate));

    // R7
    write_has_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    // R3
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_rdy) |=> (mem_en && $stable(mem_we)));

    // R2
    ir_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ir |-> $past(ld_mdr && mem_rdy));

    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (!mem_en && bus_gate == 4'b0000 && !ld_mar));

    // R7
    write_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_rdy) |=> (ld_mar && bus_gate[0]));
endmodule

bind instr_seq_ctrl instr_seq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rdy  (mem_rdy),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .ld_ir    (ld_ir),
    .ld_mdr   (ld_mdr),
    .ld_mar   (ld_mar),
    .halt     (halt),
    .bus_gate (bus_gate)
);

// File: tb/sim_instr_seq_ctrl.sv
module sim_instr_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] ir_hi = '0;
    logic [2:0] cc_nzp = '0;
    logic       mem_rdy = 1'b0;
    logic       ld_ir, ld_pc, ld_mar, ld_mdr, ld_reg, ld_cc;
    logic [3:0] bus_gate;
    logic [1:0] pc_src, addr_off, alu_op;
    logic       mar_src, mdr_src, addr_base, mem_en, mem_we, halt;
    int         n_chk = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;

    instr_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ir_hi(ir_hi), .cc_nzp(cc_nzp), .mem_rdy(mem_rdy),
        .ld_ir(ld_ir), .ld_pc(ld_pc), .ld_mar(ld_mar), .ld_mdr(ld_mdr),
        .ld_reg(ld_reg), .ld_cc(ld_cc), .bus_gate(bus_gate), .pc_src(pc_src),
        .mar_src(mar_src), .mdr_src(mdr_src), .addr_base(addr_base),
        .addr_off(addr_off), .alu_op(alu_op), .mem_en(mem_en), .mem_we(mem_we),
        .halt(halt)
    );

    // ld = {ir,pc,mar,mdr,reg,cc}; m = {mem_en,mem_we,halt}
    function automatic logic [21:0] mk(logic [5:0] ld, logic [3:0] g, logic [1:0] pcs,
                                       logic ms, logic ds, logic b, logic [1:0] o,
                                       logic [1:0] a, logic [2:0] m);
        return {ld, g, pcs, ms, ds, b, o, a, m};
    endfunction

    localparam logic [21:0] E_BOOT = mk(6'b010000, 4'b0000, 2'd2, 0, 0, 0, 2'd0, 2'd0, 3'b000);
    localparam logic [21:0] E_FADR = mk(6'b011000, 4'b0001, 2'd0, 0, 0, 0, 2'd0, 2'd0, 3'b000);
    localparam logic [21:0] E_RDW  = mk(6'b000000, 4'b0000, 2'd0, 0, 0, 0, 2'd0, 2'd0, 3'b100);
    localparam logic [21:0] E_RDD  = mk(6'b000100, 4'b0000, 2'd0, 0, 0, 0, 2'd0, 2'd0, 3'b100);
    localparam logic [21:0] E_FIR  = mk(6'b100000, 4'b0010, 2'd0, 0, 0, 0, 2'd0, 2'd0, 3'b000);
    localparam logic [21:0] E_DEC  = 22'd0;
    localparam logic [21:0] E_LEA  = mk(6'b000011, 4'b1000, 2'd0, 0, 0, 0, 2'd2, 2'd0, 3'b000);
    localparam logic [21:0] E_EAPC = mk(6'b001000, 4'b0000, 2'd0, 1, 0, 0, 2'd2, 2'd0, 3'b000);
    localparam logic [21:0] E_EABR = mk(6'b001000, 4'b0000, 2'd0, 1, 0, 1, 2'd1, 2'd0, 3'b000);
    localparam logic [21:0] E_PMAR = mk(6'b001000, 4'b0010, 2'd0, 0, 0, 0, 2'd0, 2'd0, 3'b000);
    localparam logic [21:0] E_LDWB = mk(6'b000011, 4'b0010, 2'd0, 0, 0, 0, 2'd0, 2'd0, 3'b000);
    localparam logic [21:0] E_STD  = mk(6'b000100, 4'b0100, 2'd0, 0, 1, 0, 2'd0, 2'd3, 3'b000);
    localparam logic [21:0] E_WR   = mk(6'b000000, 4'b0000, 2'd0, 0, 0, 0, 2'd0, 2'd0, 3'b110);
    localparam logic [21:0] E_BR   = mk(6'b010000, 4'b0000, 2'd1, 0, 0, 0, 2'd2, 2'd0, 3'b000);
    localparam logic [21:0] E_JMP  = mk(6'b010000, 4'b0000, 2'd1, 0, 0, 1, 2'd0, 2'd0, 3'b000);
    localparam logic [21:0] E_HALT = mk(6'b000000, 4'b0000, 2'd0, 0, 0, 0, 2'd0, 2'd0, 3'b001);

    function automatic logic [21:0] e_alu(logic [1:0] a);
        return mk(6'b000011, 4'b0100, 2'd0, 0, 0, 0, 2'd0, a, 3'b000);
    endfunction

    function automatic logic [21:0] actual();
        return {ld_ir, ld_pc, ld_mar, ld_mdr, ld_reg, ld_cc, bus_gate, pc_src,
                mar_src, mdr_src, addr_base, addr_off, alu_op, mem_en, mem_we, halt};
    endfunction

    // Called just after a falling edge; leaves just after the next falling edge.
    task automatic chk(input logic [21:0] exp, input logic rdy, input string req);
        mem_rdy = rdy;
        #1;
        n_chk++;
        if (actual() !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, actual(), exp);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic mem_read(input int lat, input string req);
        for (int i = 0; i < lat; i++) chk(E_RDW, 1'b0, {req, " R3 wait"});
        chk(E_RDD, 1'b1, req);
    endtask

    task automatic mem_write(input int lat, input string req);
        for (int i = 0; i < lat; i++) chk(E_WR, 1'b0, {req, " R3 wait"});
        chk(E_WR, 1'b1, req);
    endtask

    task automatic fetch(input logic [3:0] opc, input logic [2:0] nzp, input int lat);
        ir_hi = {opc, nzp};
        chk(E_FADR, 1'b0, "R2 fetch addr");
        mem_read(lat, "R2 fetch read");
        chk(E_FIR, 1'b0, "R2 fetch ir");
        chk(E_DEC, 1'b0, "R4 decode");
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        chk(E_BOOT, 1'b0, "R1 in reset");
        chk(E_BOOT, 1'b1, "R1 in reset");
        rst_n = 1'b1;
        chk(E_BOOT, 1'b0, "R1 boot");
    endtask

    task automatic t_operate();
        fetch(4'b0001, 3'b000, 0); chk(e_alu(2'd0), 1'b0, "R4 add");
        fetch(4'b0101, 3'b111, 1); chk(e_alu(2'd1), 1'b0, "R4 and");
        fetch(4'b1001, 3'b111, 3); chk(e_alu(2'd2), 1'b0, "R4 not");
    endtask

    task automatic t_lea();
        fetch(4'b1110, 3'b010, 1); chk(E_LEA, 1'b1, "R5 lea");
    endtask

    task automatic t_loads();
        fetch(4'b0010, 3'b000, 0); chk(E_EAPC, 1'b0, "R6 ld ea");
        mem_read(2, "R6 ld read"); chk(E_LDWB, 1'b0, "R6 ld wb");
        fetch(4'b0110, 3'b000, 1); chk(E_EABR, 1'b0, "R6 ldr ea");
        mem_read(0, "R6 ldr read"); chk(E_LDWB, 1'b0, "R6 ldr wb");
    endtask

    task automatic t_stores();
        fetch(4'b0011, 3'b000, 0); chk(E_EAPC, 1'b0, "R7 st ea");
        chk(E_STD, 1'b0, "R7 st data"); mem_write(2, "R7 st write");
        fetch(4'b0111, 3'b000, 0); chk(E_EABR, 1'b0, "R7 str ea");
        chk(E_STD, 1'b0, "R7 str data"); mem_write(0, "R7 str write");
    endtask

    task automatic t_indirect();
        fetch(4'b1010, 3'b000, 1); chk(E_EAPC, 1'b0, "R8 ldi ea");
        mem_read(3, "R8 ldi ptr"); chk(E_PMAR, 1'b0, "R8 ldi mar");
        mem_read(1, "R8 ldi data"); chk(E_LDWB, 1'b0, "R8 ldi wb");
        fetch(4'b1011, 3'b000, 0); chk(E_EAPC, 1'b0, "R8 sti ea");
        mem_read(0, "R8 sti ptr"); chk(E_PMAR, 1'b0, "R8 sti mar");
        chk(E_STD, 1'b0, "R8 sti data"); mem_write(1, "R8 sti write");
    endtask

    task automatic t_branch();
        cc_nzp = 3'b010;
        fetch(4'b0000, 3'b101, 0);       // not taken: straight back to fetch
        fetch(4'b0000, 3'b000, 0);       // empty mask: not taken
        fetch(4'b0000, 3'b011, 0); chk(E_BR, 1'b0, "R9 taken z");
        cc_nzp = 3'b100;
        fetch(4'b0000, 3'b100, 1); chk(E_BR, 1'b0, "R9 taken n");
        fetch(4'b0000, 3'b011, 0);
        chk(E_FADR, 1'b0, "R9 not taken returns to fetch");
        ir_hi = 7'd0;
        @(negedge clk);
        do_reset();
    endtask

    task automatic t_jump();
        fetch(4'b1100, 3'b000, 0); chk(E_JMP, 1'b0, "R10 jmp");
    endtask

    task automatic t_halt(input logic [3:0] opc);
        fetch(opc, 3'b111, 0);
        chk(E_HALT, 1'b0, "R11 halt");
        chk(E_HALT, 1'b1, "R11 halt held");
        chk(E_HALT, 1'b0, "R11 halt held");
        do_reset();
    endtask

    initial begin : watchdog
        #(8 * 20000);
        n_fail++;
        $display("FAIL R12 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        do_reset();
        t_operate();
        t_lea();
        t_loads();
        t_stores();
        t_indirect();
        t_jump();
        t_branch();
        t_halt(4'b1111);
        t_halt(4'b0100);
        t_halt(4'b1000);
        t_halt(4'b1101);
        t_operate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule